// File: doc/BRIEF.md
# Circular Trace Record Store with Narrow Read Window

The block keeps debug trace records in a ring of wide lines and hands them back to a host through a narrow word port. While the debug logic is armed, each store strobe writes one full-width record into the line under the write pointer. The pointer then steps forward and wraps from the last line to line 0. A saturating counter tells the host how many records were captured. Records can come from two sources. Those tagged as coming from the main processor are dropped while background debug mode is active. Records from the coprocessor are kept in all cases.

Once the debug logic is disarmed, the host reads the ring one word per read strobe. The block returns the quarters of the current line starting with the least significant one. It moves to the next line only after the last quarter of a line has been read. When disarming, the read position is set to the oldest valid record. This is line 0 if the ring never filled. If the ring filled, it is the line the next store would have overwritten. Reads made while armed return zero and do not move the read position.

Top module: `trace_ring_store`

## Requirements
- R1: After reset, `count_o` is 0.
- R2: In the cycle where `arm_i` rises, the counter, the write pointer and the read position are all cleared to line 0. A store strobe in that same cycle is dropped. Stores are accepted from the next cycle onwards.
- R3: An accepted store writes `rec_i` to the line under the write pointer, then steps the pointer. The pointer goes from line 63 back to line 0, so later records overwrite the oldest ones.
- R4: `count_o` (7 bits) goes up by one for each accepted store and stays at 64 once it gets there.
- R5: A store with `src_cpu_i`=1 (main processor source) is dropped while `bgnd_i`=1. A store with `src_cpu_i`=0 (coprocessor source) is accepted whatever the value of `bgnd_i`.
- R6: A store strobe while `arm_i`=0 has no effect on the counter or the ring contents.
- R7: While disarmed, `rd_data_o` shows one 16-bit quarter of the current read line, with word index w selecting bits [16w+15:16w]. The index starts at 0, and each read strobe moves it up by one.
- R8: The read strobe that consumes word 3 moves the read position to the next line and sets the word index back to 0. The line after 63 is 0.
- R9: While `arm_i`=1, `rd_data_o` is 16'h0000 and read strobes leave the read position unchanged.
- R10: In the cycle after `arm_i` falls, reading starts at word 0 of the oldest line. That line is 0 if `count_o` < 64, and otherwise the current write pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Debug logic armed; tracing is active while high |
| store_i | input | 1 | Store strobe, one record per cycle |
| src_cpu_i | input | 1 | 1 = record from main processor, 0 = from coprocessor |
| bgnd_i | input | 1 | Background debug mode active |
| rec_i | input | 64 | Record to store |
| rd_i | input | 1 | Read strobe for the word window |
| rd_data_o | output | 16 | Current word of the current read line |
| count_o | output | 7 | Number of records captured, saturating at 64 |

## Verification
The hardest case to reach is a ring that has overflowed. There the counter is saturated, and the write pointer has wrapped to some line other than 0. The oldest record then lies partway around the ring, and a full read-back has to cross from line 63 to line 0. The stimulus stores 70 tagged records in one armed session so that the pointer ends at line 6. It then disarms and reads all 64 lines plus one more, and each word is compared against the tag expected in that position.

// File: rtl/trb_pkg.sv
package trb_pkg;
  localparam int TRB_DEPTH  = 64;
  localparam int TRB_LINE_W = 64;
  localparam int TRB_WORD_W = 16;

  typedef enum logic {
    SRC_COPRO = 1'b0,
    SRC_CPU   = 1'b1
  } trb_src_e;
endpackage

// File: rtl/trb_ram.sv
module trb_ram #(
  parameter int DEPTH  = 64,
  parameter int LINE_W = 64,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  waddr_i,
  input  logic [LINE_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]  raddr_i,
  output logic [LINE_W-1:0] rdata_o
);
  logic [LINE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/trb_store_ctrl.sv
module trb_store_ctrl
  import trb_pkg::*;
#(
  parameter int DEPTH  = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             tracing_i,
  input  logic             store_i,
  input  trb_src_e         src_i,
  input  logic             bgnd_i,
  output logic             we_o,
  output logic [PTR_W-1:0] wptr_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] FULL      = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_LINE = PTR_W'(DEPTH - 1);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (c >= FULL) ? FULL : c + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ring_next(input logic [PTR_W-1:0] p);
    return (p == LAST_LINE) ? '0 : p + 1'b1;
  endfunction

  logic src_blocked;
  assign src_blocked = (src_i == SRC_CPU) && bgnd_i;
  assign we_o        = tracing_i && !clear_i && store_i && !src_blocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_o  <= '0;
      count_o <= '0;
    end else if (clear_i) begin
      wptr_o  <= '0;
      count_o <= '0;
    end else if (we_o) begin
      wptr_o  <= ring_next(wptr_o);
      count_o <= sat_inc(count_o);
    end
  end

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= FULL);
  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we_o && count_o < FULL) |=> count_o == $past(count_o) + 1'b1);
  assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_o && !clear_i) |=> $stable(count_o));
  assert_cpu_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (store_i && src_i == SRC_CPU && bgnd_i) |-> !we_o);
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_o && wptr_o == LAST_LINE) |=> wptr_o == '0);
endmodule

// File: rtl/trb_read_ctrl.sv
module trb_read_ctrl #(
  parameter int DEPTH = 64,
  parameter int WPL   = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH) + 1,
  localparam int IDX_W = (WPL > 1) ? $clog2(WPL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic             armed_i,
  input  logic             rd_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [PTR_W-1:0] wptr_i,
  output logic [PTR_W-1:0] rptr_o,
  output logic [IDX_W-1:0] widx_o
);
  localparam logic [CNT_W-1:0] FULL      = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_LINE = PTR_W'(DEPTH - 1);
  localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(WPL - 1);

  function automatic logic [PTR_W-1:0] oldest_line(input logic [CNT_W-1:0] c,
                                                   input logic [PTR_W-1:0] w);
    return (c >= FULL) ? w : '0;
  endfunction

  function automatic logic [PTR_W-1:0] line_next(input logic [PTR_W-1:0] p);
    return (p == LAST_LINE) ? '0 : p + 1'b1;
  endfunction

  logic step, line_done;
  assign step      = rd_i && !armed_i && !load_i;
  assign line_done = step && (widx_o == LAST_WORD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr_o <= '0;
      widx_o <= '0;
    end else if (clear_i) begin
      rptr_o <= '0;
      widx_o <= '0;
    end else if (load_i) begin
      rptr_o <= oldest_line(count_i, wptr_i);
      widx_o <= '0;
    end else if (line_done) begin
      rptr_o <= line_next(rptr_o);
      widx_o <= '0;
    end else if (step) begin
      widx_o <= widx_o + 1'b1;
    end
  end

  assert_armed_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_i && !clear_i) |=> $stable(rptr_o) && $stable(widx_o));
  assert_line_adv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> widx_o == '0 && rptr_o == line_next($past(rptr_o)));
  assert_word_adv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !line_done) |=> $stable(rptr_o) && widx_o == $past(widx_o) + 1'b1);
  assert_load_partial_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && count_i < FULL) |=> rptr_o == '0 && widx_o == '0);
endmodule

// File: rtl/trace_ring_store.sv
module trace_ring_store
  import trb_pkg::*;
#(
  parameter int DEPTH  = TRB_DEPTH,
  parameter int LINE_W = TRB_LINE_W,
  parameter int WORD_W = TRB_WORD_W,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH) + 1,
  localparam int WPL   = LINE_W / WORD_W,
  localparam int IDX_W = (WPL > 1) ? $clog2(WPL) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              store_i,
  input  logic              src_cpu_i,
  input  logic              bgnd_i,
  input  logic [LINE_W-1:0] rec_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  count_o
);
  function automatic logic [WORD_W-1:0] pick_word(input logic [LINE_W-1:0] line,
                                                  input logic [IDX_W-1:0] idx);
    return line[idx*WORD_W +: WORD_W];
  endfunction

  logic arm_q;
  always_ff @(posedge clk) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= arm_i;
  end

  logic arm_rise, arm_fall, tracing;
  assign arm_rise = arm_i && !arm_q;
  assign arm_fall = !arm_i && arm_q;
  assign tracing  = arm_i && arm_q;

  logic              we;
  logic [PTR_W-1:0]  wptr, rptr;
  logic [IDX_W-1:0]  widx;
  logic [LINE_W-1:0] rd_line;

  trb_store_ctrl #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (arm_rise),
    .tracing_i (tracing),
    .store_i   (store_i),
    .src_i     (trb_src_e'(src_cpu_i)),
    .bgnd_i    (bgnd_i),
    .we_o      (we),
    .wptr_o    (wptr),
    .count_o   (count_o)
  );

  trb_ram #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_ram (
    .clk     (clk),
    .we_i    (we),
    .waddr_i (wptr),
    .wdata_i (rec_i),
    .raddr_i (rptr),
    .rdata_o (rd_line)
  );

  trb_read_ctrl #(.DEPTH(DEPTH), .WPL(WPL)) u_read (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (arm_rise),
    .load_i  (arm_fall),
    .armed_i (arm_i),
    .rd_i    (rd_i),
    .count_i (count_o),
    .wptr_i  (wptr),
    .rptr_o  (rptr),
    .widx_o  (widx)
  );

  assign rd_data_o = arm_i ? '0 : pick_word(rd_line, widx);

  assert_arm_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arm_rise |=> count_o == '0);
  assert_disarmed_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_i |=> $stable(count_o));
  assert_no_write_armed_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> arm_i);
endmodule

// File: tb/trace_ring_store_tb.sv
module trace_ring_store_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm_i = 1'b0, store_i = 1'b0, src_cpu_i = 1'b0, bgnd_i = 1'b0, rd_i = 1'b0;
  logic [63:0] rec_i = '0;
  logic [15:0] rd_data_o;
  logic [6:0]  count_o;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trace_ring_store u_dut (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .store_i(store_i),
    .src_cpu_i(src_cpu_i), .bgnd_i(bgnd_i), .rec_i(rec_i), .rd_i(rd_i),
    .rd_data_o(rd_data_o), .count_o(count_o)
  );

  function automatic logic [63:0] tag(input int n);
    return {16'hA000 + 16'(n), 16'hB000 + 16'(n), 16'hC000 + 16'(n), 16'hD000 + 16'(n)};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic store_one(input logic [63:0] r, input logic cpu);
    @(negedge clk);
    store_i = 1'b1; rec_i = r; src_cpu_i = cpu;
    @(negedge clk);
    store_i = 1'b0;
  endtask

  task automatic set_arm(input logic a);
    @(negedge clk);
    arm_i = a;
    @(negedge clk);
  endtask

  // read nlines full lines; expected record for line j is tag(first + j)
  task automatic read_lines(input string req, input int first, input int nlines);
    for (int j = 0; j < nlines; j++) begin
      for (int w = 0; w < 4; w++) begin
        rd_i = 1'b1;
        #1;
        check(req, {48'h0, rd_data_o}, {48'h0, tag(first + j)[w*16 +: 16]});
        @(negedge clk);
      end
    end
    rd_i = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 reset count", {57'h0, count_o}, 64'd0);
  endtask

  task automatic t_arm_and_store;
    @(negedge clk);
    arm_i = 1'b1; store_i = 1'b1; rec_i = tag(99);
    @(negedge clk);
    store_i = 1'b0;
    check("R2 store in arm-rise cycle dropped", {57'h0, count_o}, 64'd0);
    for (int i = 0; i < 3; i++) store_one(tag(i), 1'b0);
    check("R4 count after three stores", {57'h0, count_o}, 64'd3);
  endtask

  task automatic t_bgnd;
    bgnd_i = 1'b1;
    store_one(tag(50), 1'b1);
    check("R5 cpu store in bgnd dropped", {57'h0, count_o}, 64'd3);
    store_one(tag(3), 1'b0);
    check("R5 coprocessor store in bgnd kept", {57'h0, count_o}, 64'd4);
    bgnd_i = 1'b0;
  endtask

  task automatic t_armed_read;
    @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      rd_i = 1'b1;
      #1;
      check("R9 armed read returns zero", {48'h0, rd_data_o}, 64'd0);
      @(negedge clk);
    end
    rd_i = 1'b0;
  endtask

  task automatic t_disarm_read;
    set_arm(1'b0);
    store_one(tag(77), 1'b0);
    check("R6 disarmed store ignored", {57'h0, count_o}, 64'd4);
    // R10: partial ring starts at line 0; R7 word order; R8 line step
    read_lines("R7 R8 R10 partial read-back", 0, 4);
  endtask

  task automatic t_overflow;
    set_arm(1'b1);
    check("R2 rearm clears count", {57'h0, count_o}, 64'd0);
    for (int i = 0; i < 70; i++) store_one(tag(i), 1'b0);
    check("R4 count saturates at 64", {57'h0, count_o}, 64'd64);
    set_arm(1'b0);
    // oldest is line 6 (record 6); crosses 63 -> 0 while reading (R3, R8)
    read_lines("R3 R8 R10 wrapped read-back", 6, 64);
    read_lines("R8 read wraps to oldest again", 6, 1);
  endtask

  task automatic t_rearm_pointers;
    set_arm(1'b1);
    store_one(tag(200), 1'b0);
    check("R2 count after rearm and one store", {57'h0, count_o}, 64'd1);
    set_arm(1'b0);
    read_lines("R2 write pointer restarted at line 0", 200, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_arm_and_store();
    t_bgnd();
    t_armed_read();
    t_disarm_read();
    t_overflow();
    t_rearm_pointers();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule